// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple valid/ready request bus and a 64K x 16 asynchronous DRAM with multiplexed addressing. Each accepted request carries a 16-bit word address, a write flag, two byte enables and write data. The controller turns it into row-strobe and column-strobe sequences, with every analog timing limit rounded up to whole clocks. A read answers with a single-cycle response that carries the data.

The controller keeps the last row open. A following request to the same row gets a short page-mode column cycle and skips the row strobe. A request to another row, a refresh grant from an outside scheduler, or a row held low too long closes the row through a precharge window. Refresh uses the column-before-row pattern, so it needs no address.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and right after reset, all strobes, write enable and output enable are high (inactive), the data bus is not driven, no response is valid, and `req_ready` is high while no refresh is requested.
- R2: Requests that follow each other to the same row (address bits 15:8) are served within one row-strobe low period, with no new row-strobe fall.
- R3: The row (address bits 15:8) is on `mem_a` at least one clock before the row strobe falls and stays there while it falls. The column (bits 7:0) is presented when the column strobes fall, so data written to an address reads back from that address.
- R4: `req_be[0]` selects the lower column strobe (data bits 7:0) and `req_be[1]` selects the upper one (bits 15:8). A write changes only the enabled bytes. Write enable is low and the write data is driven at least one clock before a column strobe falls.
- R5: A read gives `rsp_valid` high for exactly one clock. `rsp_rdata` holds the bus value captured T_CASW clocks after the column strobes fall, and each disabled byte lane reads as zero.
- R6: A request to a different row closes the open row. Between any two row-strobe low periods the row strobe stays high for at least T_RP+1 clocks.
- R7: `ref_req` is a level held until `ref_ack`. A refresh drives both column strobes low at least one clock before the row strobe falls and keeps them low for T_CHR clocks after it, with write enable high. `ref_ack` pulses for one clock. In idle a refresh wins over a waiting request, and an open row is closed first.
- R8: The row strobe never stays low for more than T_RAS_MAX clocks. A long run of same-row requests closes the row and reopens it, and no write is lost.
- R9: Output enable is low only during read column cycles. It is never low while write enable is low or while the controller drives the bus. After a write, the bus stays driven for one clock after the column strobes rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this clock edge |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_be | input | 2 | Byte enables, bit 1 for the upper byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one clock |
| rsp_rdata | output | 16 | Read data, disabled bytes zero |
| ref_req | input | 1 | Refresh grant, held until acknowledged |
| ref_ack | output | 1 | Refresh done, one clock |
| mem_rowstb_n | output | 1 | Row address strobe, active low |
| mem_colstb_hi_n | output | 1 | Upper byte column strobe, active low |
| mem_colstb_lo_n | output | 1 | Lower byte column strobe, active low |
| mem_wr_n | output | 1 | Write enable, active low |
| mem_rd_en_n | output | 1 | Output enable, active low |
| mem_a | output | ROW_W | Multiplexed row/column address |
| mem_dq_o | output | 16 | Write data to the bus |
| mem_dq_drive | output | 1 | Bus driver enable |
| mem_dq_i | input | 16 | Data from the bus |

## Verification
The assertions assume two things about the inputs. A requester holds `req_valid` and its fields steady until the request is taken. The scheduler holds `ref_req` until `ref_ack` and then drops it within the precharge window. The bench changes inputs only half a clock after the active edge and follows both rules. Its memory model drives read data only while output enable is low, and the controller's sampling point falls inside that window. Only row and column values below 16 are used, so the small model memory never aliases two addresses.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int T_RCD     = 2,
  parameter int T_CASW    = 2,
  parameter int T_RP      = 4,
  parameter int T_RFW     = 4,
  parameter int T_CHR     = 1,
  parameter int T_RAS_MAX = 9000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [1:0]             req_be,
  input  logic [15:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [15:0]            rsp_rdata,
  input  logic                   ref_req,
  output logic                   ref_ack,
  output logic                   mem_rowstb_n,
  output logic                   mem_colstb_hi_n,
  output logic                   mem_colstb_lo_n,
  output logic                   mem_wr_n,
  output logic                   mem_rd_en_n,
  output logic [ROW_W-1:0]       mem_a,
  output logic [15:0]            mem_dq_o,
  output logic                   mem_dq_drive,
  input  logic [15:0]            mem_dq_i
);
  localparam int AW    = ROW_W + COL_W;
  localparam int M1    = (T_RCD > T_CASW) ? T_RCD : T_CASW;
  localparam int M2    = (T_RP > T_RFW) ? T_RP : T_RFW;
  localparam int TMAX  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int RW    = $clog2(T_RAS_MAX + 1);
  localparam logic [RW-1:0] RAS_LIM = RW'(T_RAS_MAX - T_CASW - 3);

  typedef enum logic [3:0] {
    S_IDLE, S_RADDR, S_RCD, S_CADDR, S_COL, S_OPEN, S_PRE, S_RCBR, S_RREF
  } st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic [RW-1:0]    ras_cnt;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q, rel_q;
  logic [1:0]       be_q;
  logic [15:0]      wdata_q;

  wire hit     = req_addr[AW-1:COL_W] == row_q;
  wire tmo     = ras_cnt > RAS_LIM;
  wire row_low = state inside {S_RCD, S_CADDR, S_COL, S_OPEN, S_RREF};
  wire col_cyc = state inside {S_CADDR, S_COL};
  wire col_act = state == S_COL;
  wire cbr_cas = (state == S_RCBR) || (state == S_RREF && cnt < CNT_W'(T_CHR));
  wire col_end = col_act && cnt == CNT_W'(T_CASW - 1);

  assign req_ready = !ref_req && ((state == S_IDLE) || (state == S_OPEN && !tmo && hit));

  assign mem_rowstb_n    = !row_low;
  assign mem_colstb_hi_n = !((col_act && be_q[1]) || cbr_cas);
  assign mem_colstb_lo_n = !((col_act && be_q[0]) || cbr_cas);
  assign mem_wr_n        = !(col_cyc && wr_q);
  assign mem_rd_en_n     = !(col_act && !wr_q);
  assign mem_a           = col_cyc ? ROW_W'(col_q) : row_q;
  assign mem_dq_o        = wdata_q;
  assign mem_dq_drive    = (col_cyc && wr_q) || rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      ras_cnt   <= '0;
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      be_q      <= '0;
      wdata_q   <= '0;
      rel_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ref_ack   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      ref_ack   <= 1'b0;
      rel_q     <= 1'b0;
      cnt       <= cnt + CNT_W'(1);
      ras_cnt   <= row_low ? ras_cnt + RW'(1) : '0;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (ref_req) state <= S_RCBR;
          else if (req_valid) begin
            row_q   <= req_addr[AW-1:COL_W];
            col_q   <= req_addr[COL_W-1:0];
            wr_q    <= req_write;
            be_q    <= req_be;
            wdata_q <= req_wdata;
            state   <= S_RADDR;
          end
        end
        S_RADDR: begin
          cnt   <= '0;
          state <= S_RCD;
        end
        S_RCD: if (cnt == CNT_W'(T_RCD - 1)) begin
          cnt   <= '0;
          state <= S_CADDR;
        end
        S_CADDR: begin
          cnt   <= '0;
          state <= S_COL;
        end
        S_COL: if (col_end) begin
          cnt   <= '0;
          rel_q <= wr_q;
          state <= S_OPEN;
          if (!wr_q) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= {be_q[1] ? mem_dq_i[15:8] : 8'h00, be_q[0] ? mem_dq_i[7:0] : 8'h00};
          end
        end
        S_OPEN: begin
          cnt <= '0;
          if (ref_req || tmo || (req_valid && !hit)) state <= S_PRE;
          else if (req_valid) begin
            col_q   <= req_addr[COL_W-1:0];
            wr_q    <= req_write;
            be_q    <= req_be;
            wdata_q <= req_wdata;
            state   <= S_CADDR;
          end
        end
        S_PRE: if (cnt == CNT_W'(T_RP - 1)) begin
          cnt   <= '0;
          state <= S_IDLE;
        end
        S_RCBR: begin
          cnt   <= '0;
          state <= S_RREF;
        end
        S_RREF: if (cnt == CNT_W'(T_RFW - 1)) begin
          cnt     <= '0;
          ref_ack <= 1'b1;
          state   <= S_PRE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RP      = 4,
  parameter int T_RAS_MAX = 9000
) (
  input logic clk,
  input logic rst_n,
  input logic rowstb_n,
  input logic colhi_n,
  input logic collo_n,
  input logic wr_n,
  input logic rd_en_n,
  input logic dq_drive,
  input logic rsp_valid
);
  localparam int LW = $clog2(T_RAS_MAX + 2);
  localparam int HW = $clog2(T_RP + 3);
  localparam logic [HW-1:0] HMAX = HW'(T_RP + 1);
  localparam logic [LW-1:0] LMAX = LW'(T_RAS_MAX);

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;
  logic          seen_rise, row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      high_cnt  <= '0;
      seen_rise <= 1'b0;
      row_q     <= 1'b1;
    end else begin
      row_q    <= rowstb_n;
      low_cnt  <= rowstb_n ? '0 : low_cnt + LW'(1);
      high_cnt <= !rowstb_n ? '0 : ((high_cnt == HMAX) ? HMAX : high_cnt + HW'(1));
      if (rowstb_n && !row_q) seen_rise <= 1'b1;
    end
  end

  // R4
  early_wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(collo_n) && !wr_n) |-> ($past(!wr_n) && dq_drive));
  // R4
  early_wr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(colhi_n) && !wr_n) |-> ($past(!wr_n) && dq_drive));
  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R6
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rowstb_n) && seen_rise) |-> (high_cnt == HMAX));
  // R7
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rowstb_n) && !colhi_n && !collo_n) |-> (wr_n && $past(!colhi_n && !collo_n)));
  // R8
  row_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rowstb_n |-> (low_cnt < LMAX));
  // R9
  oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_n |-> (wr_n && !dq_drive && !rowstb_n));
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .rowstb_n(mem_rowstb_n), .colhi_n(mem_colstb_hi_n),
  .collo_n(mem_colstb_lo_n), .wr_n(mem_wr_n), .rd_en_n(mem_rd_en_n),
  .dq_drive(mem_dq_drive), .rsp_valid(rsp_valid)
);

// File: tb/tb_fpm_dram_ctrl.sv
module tb_fpm_dram_ctrl;
  localparam int RASMAX = 40;
  localparam int TRP    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, rsp_rdata, mem_dq_o, mem_dq_i;
  logic [1:0]  req_be = '0;
  logic        rsp_valid, ref_req = 1'b0, ref_ack;
  logic        mem_rowstb_n, mem_colstb_hi_n, mem_colstb_lo_n, mem_wr_n, mem_rd_en_n, mem_dq_drive;
  logic [7:0]  mem_a;

  fpm_dram_ctrl #(.T_RP(TRP), .T_RAS_MAX(RASMAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_ack(ref_ack),
    .mem_rowstb_n(mem_rowstb_n), .mem_colstb_hi_n(mem_colstb_hi_n),
    .mem_colstb_lo_n(mem_colstb_lo_n), .mem_wr_n(mem_wr_n), .mem_rd_en_n(mem_rd_en_n),
    .mem_a(mem_a), .mem_dq_o(mem_dq_o), .mem_dq_drive(mem_dq_drive), .mem_dq_i(mem_dq_i)
  );

  logic [15:0] mem  [0:255];
  logic [15:0] expm [0:255];
  logic [7:0]  row_l = '0, col_l = '0;
  assign mem_dq_i = !mem_rd_en_n ? mem[{row_l[3:0], col_l[3:0]}] : 16'h0000;

  int row_falls = 0, cbr_cnt = 0, cbr_we_viol = 0, asr_viol = 0, early_viol = 0;
  int oe_conf = 0, rel_viol = 0, low_run = 0, high_run = 0, max_low = 0, min_high = 1000;
  bit seen_rise = 1'b0;
  logic p_row = 1'b1, p_hi = 1'b1, p_lo = 1'b1, p_we = 1'b1;
  logic [7:0] p_a = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5A3C;
    end else begin
      if (mem_rowstb_n) begin
        if (!p_row) begin
          seen_rise = 1'b1;
          if (low_run > max_low) max_low = low_run;
          low_run = 0;
          high_run = 0;
        end
        high_run++;
      end else begin
        if (p_row) begin
          if (seen_rise && high_run < min_high) min_high = high_run;
          if (!p_hi && !p_lo) begin
            cbr_cnt++;
            if (!mem_wr_n) cbr_we_viol++;
          end else begin
            row_falls++;
            row_l = mem_a;
            if (mem_a != p_a) asr_viol++;
          end
        end
        low_run++;
      end
      if (!mem_rowstb_n && ((p_hi && !mem_colstb_hi_n) || (p_lo && !mem_colstb_lo_n))) begin
        col_l = mem_a;
        if (!mem_wr_n) begin
          if (p_we) early_viol++;
          if (!mem_dq_drive) early_viol++;
          if (p_hi && !mem_colstb_hi_n) mem[{row_l[3:0], col_l[3:0]}][15:8] = mem_dq_o[15:8];
          if (p_lo && !mem_colstb_lo_n) mem[{row_l[3:0], col_l[3:0]}][7:0] = mem_dq_o[7:0];
        end
      end
      if (!mem_rd_en_n && (mem_dq_drive || !mem_wr_n)) oe_conf++;
      if ((!p_hi || !p_lo) && mem_colstb_hi_n && mem_colstb_lo_n && !p_we && !mem_dq_drive) rel_viol++;
      p_row = mem_rowstb_n; p_hi = mem_colstb_hi_n; p_lo = mem_colstb_lo_n;
      p_we = mem_wr_n; p_a = mem_a;
    end
  end

  int checks = 0, errors = 0;
  bit wd = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic int idx(input logic [15:0] a);
    return {a[11:8], a[3:0]};
  endfunction

  task automatic send(input bit w, input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
    step();
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    #1;
    while (!req_ready) step();
    step();
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
    send(1'b1, a, be, d);
    if (be[1]) expm[idx(a)][15:8] = d[15:8];
    if (be[0]) expm[idx(a)][7:0] = d[7:0];
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] be, output logic [15:0] d, output bit single);
    bit got = 1'b0;
    send(1'b0, a, be, 16'h0);
    d = 16'hxxxx;
    for (int i = 0; i < 60; i++) begin
      if (rsp_valid) begin d = rsp_rdata; got = 1'b1; break; end
      step();
    end
    step();
    single = got && !rsp_valid;
  endtask

  function automatic logic [15:0] expv(input logic [15:0] a, input logic [1:0] be);
    return {be[1] ? expm[idx(a)][15:8] : 8'h00, be[0] ? expm[idx(a)][7:0] : 8'h00};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_refresh(output bit acked);
    acked = 1'b0;
    step();
    ref_req = 1'b1;
    for (int i = 0; i < 100; i++) begin
      step();
      if (ref_ack) begin acked = 1'b1; ref_req = 1'b0; break; end
    end
    ref_req = 1'b0;
  endtask

  task automatic t_reset();
    chk(mem_rowstb_n && mem_colstb_hi_n && mem_colstb_lo_n, "R1 strobes in reset",
        {mem_rowstb_n, mem_colstb_hi_n, mem_colstb_lo_n}, 3'b111);
    chk(mem_wr_n && mem_rd_en_n && !mem_dq_drive, "R1 we/oe/drive in reset",
        {mem_wr_n, mem_rd_en_n, mem_dq_drive}, 3'b110);
    rst_n = 1'b1;
    step();
    chk(mem_rowstb_n && mem_colstb_hi_n && mem_colstb_lo_n, "R1 strobes after reset",
        {mem_rowstb_n, mem_colstb_hi_n, mem_colstb_lo_n}, 3'b111);
    chk(!rsp_valid && !ref_ack, "R1 no response after reset", {rsp_valid, ref_ack}, 0);
    chk(req_ready, "R1 ready in idle", req_ready, 1);
  endtask

  task automatic t_page();
    int f0 = row_falls;
    logic [15:0] d;
    bit s;
    wr(16'h0203, 2'b11, 16'h1234);
    wr(16'h0204, 2'b11, 16'h5678);
    rd(16'h0203, 2'b11, d, s);
    chk(d === 16'h1234, "R3 read back word", d, 16'h1234);
    chk(s, "R5 single response pulse", s, 1);
    rd(16'h0204, 2'b11, d, s);
    chk(d === 16'h5678, "R2 page hit data", d, 16'h5678);
    chk(row_falls - f0 == 1, "R2 one row open for page hits", row_falls - f0, 1);
  endtask

  task automatic t_bytes();
    logic [15:0] d;
    bit s;
    wr(16'h0208, 2'b11, 16'hAAAA);
    wr(16'h0208, 2'b01, 16'h3355);
    rd(16'h0208, 2'b11, d, s);
    chk(d === expv(16'h0208, 2'b11), "R4 lower byte write", d, expv(16'h0208, 2'b11));
    wr(16'h0208, 2'b10, 16'h12FF);
    rd(16'h0208, 2'b11, d, s);
    chk(d === 16'h1255, "R4 upper byte write", d, 16'h1255);
    rd(16'h0208, 2'b01, d, s);
    chk(d === 16'h0055, "R5 lower byte read masks upper", d, 16'h0055);
    rd(16'h0208, 2'b10, d, s);
    chk(d === 16'h1200, "R5 upper byte read masks lower", d, 16'h1200);
    chk(early_viol == 0, "R4 early write timing", early_viol, 0);
  endtask

  task automatic t_miss();
    int f0 = row_falls;
    logic [15:0] d;
    bit s;
    rd(16'h0503, 2'b11, d, s);
    chk(d === expv(16'h0503, 2'b11), "R6 first row data", d, expv(16'h0503, 2'b11));
    rd(16'h0603, 2'b11, d, s);
    chk(d === expv(16'h0603, 2'b11), "R6 missed row data", d, expv(16'h0603, 2'b11));
    rd(16'h0503, 2'b11, d, s);
    chk(row_falls - f0 == 3, "R6 each miss reopens", row_falls - f0, 3);
    chk(min_high >= TRP + 1, "R6 precharge width", min_high, TRP + 1);
  endtask

  task automatic t_refresh();
    int c0 = cbr_cnt;
    int f0 = row_falls;
    logic [15:0] d;
    bit s, ack;
    do_refresh(ack);
    chk(ack, "R7 refresh acknowledged", ack, 1);
    chk(cbr_cnt - c0 == 1, "R7 one column-first refresh", cbr_cnt - c0, 1);
    chk(cbr_we_viol == 0, "R7 write enable high in refresh", cbr_we_viol, 0);
    idle(4);
    rd(16'h0503, 2'b11, d, s);
    chk(row_falls - f0 == 1 && d === expv(16'h0503, 2'b11), "R7 row closed by refresh",
        row_falls - f0, 1);
  endtask

  task automatic t_prio();
    int c0, r0, first = 0;
    bit acc = 1'b0;
    logic [15:0] d;
    bit s;
    step();
    c0 = cbr_cnt; r0 = row_falls;
    ref_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0909; req_be = 2'b11; req_wdata = 16'hBEEF;
    for (int i = 0; i < 200; i++) begin
      step();
      if (first == 0) begin
        if (cbr_cnt != c0) first = 1;
        else if (row_falls != r0) first = 2;
      end
      if (ref_ack) ref_req = 1'b0;
      if (acc) req_valid = 1'b0;
      acc = req_valid && req_ready;
      if (!ref_req && !req_valid) break;
    end
    ref_req = 1'b0; req_valid = 1'b0;
    expm[idx(16'h0909)] = 16'hBEEF;
    chk(first == 1, "R7 refresh before waiting request", first, 1);
    rd(16'h0909, 2'b11, d, s);
    chk(d === 16'hBEEF, "R7 request served after refresh", d, 16'hBEEF);
  endtask

  task automatic t_timeout();
    int f0 = row_falls;
    logic [15:0] d;
    bit s;
    for (int i = 0; i < 12; i++) wr(16'h0700 + 16'(i), 2'b11, 16'hC000 + 16'(i));
    rd(16'h070B, 2'b11, d, s);
    chk(d === 16'hC00B, "R8 last write of long burst", d, 16'hC00B);
    rd(16'h0700, 2'b11, d, s);
    chk(d === 16'hC000, "R8 first write of long burst", d, 16'hC000);
    chk(row_falls - f0 >= 2, "R8 burst row reopened", row_falls - f0, 2);
    chk(max_low <= RASMAX && low_run <= RASMAX, "R8 row active limit", max_low, RASMAX);
  endtask

  task automatic t_bus();
    chk(oe_conf == 0, "R9 output enable exclusive", oe_conf, 0);
    chk(rel_viol == 0, "R9 drive held after strobe rise", rel_viol, 0);
    chk(asr_viol == 0, "R3 row address set up before strobe", asr_viol, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) expm[i] = 16'(i * 257) ^ 16'h5A3C;
    repeat (3) @(negedge clk);
    #1;
    fork
      begin
        t_reset();
        t_page();
        t_bytes();
        t_miss();
        t_refresh();
        t_prio();
        t_timeout();
        t_bus();
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule